// File: doc/BRIEF.md
# Prioritized Interrupt Delivery Controller

This block collects a small set of external interrupt lines, each of which can be set up as edge or level sensitive with a chosen active polarity. It routes each line to one or more CPUs through a per-source destination mask. For every CPU it picks the best eligible source and raises that CPU's interrupt output. Software takes the interrupt by reading the CPU's acknowledge register, which returns the source's programmed vector and marks the source in service. A later write to the CPU's end-of-interrupt register retires the highest-priority source that is in service on that CPU. Each CPU also has a task priority that sets how high a source's priority must be before it can interrupt that CPU.

All configuration sits behind a single-cycle word-addressed register bus. Read data is registered and is valid after the clock edge that samples the read strobe. A global configuration register has a self-clearing controller-reset bit and a stored passthrough-disable bit. A read-only feature word reports the sizes of the block.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, source s reads back `0x8008_0000 | s` from its vector/priority word at word address 16+2s. Bit 31 is the mask, bits 19:16 the priority, bit 23 the polarity (1 = active high or rising), bit 22 the sense (1 = level) and bits 7:0 the vector. After reset the destination word (address 17+2s) reads 0, each CPU's task priority (address 128+4c) reads 15, the spurious vector (address 2) reads 0xFF, the global configuration (address 0) reads 0, and no interrupt output is asserted.
- R2: The feature word at address 1 reads the number of sources minus one in bits 7:0, the number of CPUs minus one in bits 15:8, and the version in bits 23:16.
- R3: A read of CPU c's acknowledge register (address 129+4c) returns the vector of the eligible pending source with the highest priority. When several sources share that priority, the lowest source number wins.
- R4: A source is presented only to the CPUs whose bit is set in its destination word.
- R5: A source is eligible for CPU c only if its priority is strictly above c's task priority. A task priority of 15 blocks every source, and a source with priority 0 is never delivered.
- R6: When nothing qualifies, the acknowledge read returns the spurious vector and changes no in-service state.
- R7: An acknowledged source is marked in service on that CPU and is not presented again while it is in service. A CPU's interrupt output and acknowledge delivery also require a priority strictly above the highest priority in service on that CPU.
- R8: Any write to CPU c's end-of-interrupt register (address 130+4c) retires only the highest-priority source in service on c. A lower source that was nested beneath it remains in service.
- R9: An edge source latches a rising edge (polarity 1) or a falling edge (polarity 0). An edge that arrives while the source is in service is delivered after the end of interrupt. Each edge is delivered once.
- R10: A level source is pending while its input is at the active level. After the end of interrupt it is presented again if its input is still active, and it is not presented if the input has dropped.
- R11: A masked source is never presented. A change to the mask bit is visible on the next read-back of the vector/priority word.
- R12: Writing 1 to bit 31 of the global configuration starts a controller reset. That bit reads 1 until the reset completes and then clears, leaving all source, CPU and global settings at their R1 values with outputs low throughout. Bit 29 (passthrough disable) can be written and read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_SRC | External interrupt lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered on the edge that samples bus_rd |
| cpu_int | output | N_CPU | Interrupt request, one per CPU |

## Verification
A corrupted in-service set shows up at the ports on the very next acknowledge or end-of-interrupt. Either a nested lower source is offered too early, a source that was retired stays blocked, or the interrupt output stays low with eligible work pending. A wrong edge latch shows up as a missing or repeated vector within a few cycles of the input transition. A wrong arbitration path shows up as a vector read that is wrong, which the bench detects by returning a distinct vector for every source. The soft-reset sequence is checked for its busy bit and for the register values it leaves behind.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
   // Field positions inside a source's vector/priority word
   localparam int VP_MASK    = 31;
   localparam int VP_POL     = 23;
   localparam int VP_SENSE   = 22;
   localparam int VP_PRI_LSB = 16;
   // Global configuration bits
   localparam int GC_RESET   = 31;
   localparam int GC_PTDIS   = 29;
   // Address map (word addresses)
   localparam int A_GCFG     = 0;
   localparam int A_FEAT     = 1;
   localparam int A_SPUR     = 2;
   localparam int SRC_BASE   = 16;
   localparam int SRC_STRIDE = 2;
   localparam int CPU_BASE   = 128;
   localparam int CPU_STRIDE = 4;
   typedef enum int {CR_TASK = 0, CR_IACK = 1, CR_EOI = 2} cpu_reg_e;
endpackage

// File: rtl/pirq_src.sv
module pirq_src
   import pirq_pkg::*;
#(
   parameter int IDX     = 0,
   parameter int N_CPU   = 2,
   parameter int PW      = 4,
   parameter int VW      = 8,
   parameter int PRI_RST = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_cfg,
   input  logic              irq_raw,
   input  logic              wr_vp,
   input  logic              wr_dst,
   input  logic [31:0]       wdata,
   input  logic              acked,
   output logic [31:0]       vp_word,
   output logic [N_CPU-1:0]  dst,
   output logic [PW-1:0]     pri,
   output logic [VW-1:0]     vec,
   output logic              masked,
   output logic              pend
);
   logic msk, pol, lvl;
   logic irq_q, irq_q2, latch;
   logic act, act_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msk <= 1'b1; pol <= 1'b0; lvl <= 1'b0;
         pri <= PW'(PRI_RST); vec <= VW'(IDX);
      end else if (clr_cfg) begin
         msk <= 1'b1; pol <= 1'b0; lvl <= 1'b0;
         pri <= PW'(PRI_RST); vec <= VW'(IDX);
      end else if (wr_vp) begin
         msk <= wdata[VP_MASK];
         pol <= wdata[VP_POL];
         lvl <= wdata[VP_SENSE];
         pri <= wdata[VP_PRI_LSB +: PW];
         vec <= wdata[VW-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dst <= '0;
      else if (clr_cfg) dst <= '0;
      else if (wr_dst)  dst <= wdata[N_CPU-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0; irq_q2 <= 1'b0;
      end else begin
         irq_q <= irq_raw; irq_q2 <= irq_q;
      end
   end

   assign act      = (irq_q == pol);
   assign act_prev = (irq_q2 == pol);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         latch <= 1'b0;
      else if (clr_cfg)                   latch <= 1'b0;
      else if (!lvl && act && !act_prev)  latch <= 1'b1;
      else if (acked)                     latch <= 1'b0;
   end

   assign pend   = lvl ? act : latch;
   assign masked = msk;

   always_comb begin
      vp_word                   = '0;
      vp_word[VP_MASK]          = msk;
      vp_word[VP_POL]           = pol;
      vp_word[VP_SENSE]         = lvl;
      vp_word[VP_PRI_LSB +: PW] = pri;
      vp_word[VW-1:0]           = vec;
   end
endmodule

// File: rtl/pirq_pick.sv
module pirq_pick #(
   parameter int N  = 4,
   parameter int PW = 4,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]         elig,
   input  logic [N-1:0][PW-1:0] pri,
   output logic                 any,
   output logic [IW-1:0]        idx,
   output logic [PW-1:0]        best
);
   // Strictly-greater compare keeps the lowest index on ties
   always_comb begin
      any  = 1'b0;
      idx  = '0;
      best = '0;
      for (int i = 0; i < N; i++) begin
         if (elig[i] && (!any || pri[i] > best)) begin
            any  = 1'b1;
            idx  = IW'(i);
            best = pri[i];
         end
      end
   end
endmodule

// File: rtl/pirq_cpu.sv
module pirq_cpu #(
   parameter int N_SRC = 4,
   parameter int PW    = 4,
   parameter int IW    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr_cfg,
   input  logic                     wr_task,
   input  logic [PW-1:0]            task_wdata,
   input  logic                     ack,
   input  logic [IW-1:0]            ack_idx,
   input  logic                     eoi,
   input  logic [N_SRC-1:0][PW-1:0] src_pri,
   output logic [PW-1:0]            task_pri,
   output logic [N_SRC-1:0]         insvc,
   output logic [PW-1:0]            isr_pri
);
   logic          isr_any;
   logic [IW-1:0] top_idx;
   logic [N_SRC-1:0] insvc_nxt;

   // The in-service set reuses the arbiter to find its top entry
   pirq_pick #(.N(N_SRC), .PW(PW), .IW(IW)) u_top (
      .elig (insvc),
      .pri  (src_pri),
      .any  (isr_any),
      .idx  (top_idx),
      .best (isr_pri)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       task_pri <= '1;
      else if (clr_cfg) task_pri <= '1;
      else if (wr_task) task_pri <= task_wdata;
   end

   always_comb begin
      insvc_nxt = insvc;
      if (eoi && isr_any) insvc_nxt[top_idx] = 1'b0;
      if (ack)            insvc_nxt[ack_idx] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       insvc <= '0;
      else if (clr_cfg) insvc <= '0;
      else              insvc <= insvc_nxt;
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import pirq_pkg::*;
#(
   parameter int N_SRC    = 4,
   parameter int N_CPU    = 2,
   parameter int PW       = 4,
   parameter int VW       = 8,
   parameter int ADDR_W   = 8,
   parameter int RST_CYC  = 4,
   parameter int VERSION  = 2,
   parameter int SPUR_RST = 255,
   parameter int PRI_RST  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  irq_in,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [N_CPU-1:0]  cpu_int
);
   localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;
   localparam int CW = $clog2(RST_CYC + 1);

   if (N_SRC < 2 || SRC_BASE + SRC_STRIDE * N_SRC > CPU_BASE) begin : g_bad_src
      $error("N_SRC out of range");
   end
   if (N_CPU < 1 || CPU_BASE + CPU_STRIDE * N_CPU > (1 << ADDR_W)) begin : g_bad_cpu
      $error("N_CPU out of range");
   end
   if (PW < 1 || PW > 6 || VW < 1 || VW > 16) begin : g_bad_fld
      $error("field width out of range");
   end
   if (ADDR_W < 8 || RST_CYC < 1) begin : g_bad_misc
      $error("ADDR_W or RST_CYC out of range");
   end

   // Global state
   logic [CW-1:0] rst_cnt;
   logic          soft_go, soft_rst, clr_cfg, ptdis;
   logic [VW-1:0] spur;

   // Per-source state
   logic [31:0]             vp_word [N_SRC];
   logic [VW-1:0]           vec     [N_SRC];
   logic [N_SRC-1:0][N_CPU-1:0] dst;
   logic [N_SRC-1:0][PW-1:0]    pri;
   logic [N_SRC-1:0]        masked, pend, wr_vp, wr_dst, acked, insvc_any;

   // Per-CPU state
   logic [N_CPU-1:0][PW-1:0]    task_pri, isr_pri, win_pri;
   logic [N_CPU-1:0][N_SRC-1:0] insvc, elig;
   logic [N_CPU-1:0][IW-1:0]    win_idx;
   logic [N_CPU-1:0]            win_any, deliver, wr_task, iack, eoi;
   logic [31:0]                 rd_nxt;

   assign soft_go  = bus_wr && (bus_addr == ADDR_W'(A_GCFG)) && bus_wdata[GC_RESET];
   assign soft_rst = (rst_cnt != '0);
   assign clr_cfg  = soft_go || soft_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            rst_cnt <= '0;
      else if (soft_go)      rst_cnt <= CW'(RST_CYC);
      else if (soft_rst)     rst_cnt <= rst_cnt - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptdis <= 1'b0;
         spur  <= VW'(SPUR_RST);
      end else if (clr_cfg) begin
         ptdis <= 1'b0;
         spur  <= VW'(SPUR_RST);
      end else if (bus_wr) begin
         if (bus_addr == ADDR_W'(A_GCFG)) ptdis <= bus_wdata[GC_PTDIS];
         if (bus_addr == ADDR_W'(A_SPUR)) spur  <= bus_wdata[VW-1:0];
      end
   end

   // Address decode
   always_comb begin
      wr_vp = '0; wr_dst = '0; wr_task = '0; iack = '0; eoi = '0;
      for (int s = 0; s < N_SRC; s++) begin
         if (bus_addr == ADDR_W'(SRC_BASE + SRC_STRIDE * s))     wr_vp[s]  = bus_wr;
         if (bus_addr == ADDR_W'(SRC_BASE + SRC_STRIDE * s + 1)) wr_dst[s] = bus_wr;
      end
      for (int c = 0; c < N_CPU; c++) begin
         if (bus_addr == ADDR_W'(CPU_BASE + CPU_STRIDE * c + CR_TASK)) wr_task[c] = bus_wr;
         if (bus_addr == ADDR_W'(CPU_BASE + CPU_STRIDE * c + CR_IACK)) iack[c]    = bus_rd;
         if (bus_addr == ADDR_W'(CPU_BASE + CPU_STRIDE * c + CR_EOI))  eoi[c]     = bus_wr;
      end
   end

   // Sources
   for (genvar s = 0; s < N_SRC; s++) begin : g_src
      pirq_src #(.IDX(s), .N_CPU(N_CPU), .PW(PW), .VW(VW), .PRI_RST(PRI_RST)) u_src (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr_cfg (clr_cfg),
         .irq_raw (irq_in[s]),
         .wr_vp   (wr_vp[s]),
         .wr_dst  (wr_dst[s]),
         .wdata   (bus_wdata),
         .acked   (acked[s]),
         .vp_word (vp_word[s]),
         .dst     (dst[s]),
         .pri     (pri[s]),
         .vec     (vec[s]),
         .masked  (masked[s]),
         .pend    (pend[s])
      );
   end

   // Eligibility, delivery and acknowledge fan-in
   always_comb begin
      insvc_any = '0;
      for (int c = 0; c < N_CPU; c++) insvc_any = insvc_any | insvc[c];
      for (int c = 0; c < N_CPU; c++) begin
         for (int s = 0; s < N_SRC; s++) begin
            elig[c][s] = pend[s] && !masked[s] && dst[s][c] && !insvc_any[s]
                         && (pri[s] > task_pri[c]);
         end
         deliver[c] = win_any[c] && (win_pri[c] > isr_pri[c]);
      end
      acked = '0;
      for (int c = 0; c < N_CPU; c++) begin
         for (int s = 0; s < N_SRC; s++) begin
            if (iack[c] && deliver[c] && win_idx[c] == IW'(s)) acked[s] = 1'b1;
         end
      end
   end

   assign cpu_int = deliver;

   // CPUs
   for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
      pirq_pick #(.N(N_SRC), .PW(PW), .IW(IW)) u_pick (
         .elig (elig[c]),
         .pri  (pri),
         .any  (win_any[c]),
         .idx  (win_idx[c]),
         .best (win_pri[c])
      );
      pirq_cpu #(.N_SRC(N_SRC), .PW(PW), .IW(IW)) u_cpu (
         .clk        (clk),
         .rst_n      (rst_n),
         .clr_cfg    (clr_cfg),
         .wr_task    (wr_task[c]),
         .task_wdata (bus_wdata[PW-1:0]),
         .ack        (iack[c] && deliver[c]),
         .ack_idx    (win_idx[c]),
         .eoi        (eoi[c]),
         .src_pri    (pri),
         .task_pri   (task_pri[c]),
         .insvc      (insvc[c]),
         .isr_pri    (isr_pri[c])
      );
   end

   // Read mux
   always_comb begin
      rd_nxt = '0;
      if (bus_addr == ADDR_W'(A_GCFG)) begin
         rd_nxt[GC_RESET] = soft_rst;
         rd_nxt[GC_PTDIS] = ptdis;
      end
      if (bus_addr == ADDR_W'(A_FEAT)) begin
         rd_nxt[7:0]   = 8'(N_SRC - 1);
         rd_nxt[15:8]  = 8'(N_CPU - 1);
         rd_nxt[23:16] = 8'(VERSION);
      end
      if (bus_addr == ADDR_W'(A_SPUR)) rd_nxt[VW-1:0] = spur;
      for (int s = 0; s < N_SRC; s++) begin
         if (bus_addr == ADDR_W'(SRC_BASE + SRC_STRIDE * s))     rd_nxt = vp_word[s];
         if (bus_addr == ADDR_W'(SRC_BASE + SRC_STRIDE * s + 1)) rd_nxt[N_CPU-1:0] = dst[s];
      end
      for (int c = 0; c < N_CPU; c++) begin
         if (bus_addr == ADDR_W'(CPU_BASE + CPU_STRIDE * c + CR_TASK))
            rd_nxt[PW-1:0] = task_pri[c];
         if (bus_addr == ADDR_W'(CPU_BASE + CPU_STRIDE * c + CR_IACK))
            rd_nxt[VW-1:0] = deliver[c] ? vec[win_idx[c]] : spur;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_nxt;
   end
endmodule

// File: rtl/pirq_chk.sv
module pirq_chk #(
   parameter int N_SRC  = 4,
   parameter int N_CPU  = 2,
   parameter int ADDR_W = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     bus_rd,
   input logic                     bus_wr,
   input logic [ADDR_W-1:0]        bus_addr,
   input logic [31:0]              bus_rdata,
   input logic [N_CPU-1:0]         cpu_int,
   input logic                     soft_rst,
   input logic [N_CPU-1:0][N_SRC-1:0] insvc
);
   // R12
   soft_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |-> cpu_int == '0);

   // R12
   gcfg_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == '0) |=> bus_rdata[31] == $past(soft_rst));

   for (genvar c = 0; c < N_CPU; c++) begin : g_c
      // R7
      ack_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && !bus_wr && bus_addr == ADDR_W'(129 + 4 * c) && cpu_int[c])
         |=> $countones(insvc[c]) == $countones($past(insvc[c])) + 1);

      // R6
      spur_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && !bus_wr && !soft_rst && bus_addr == ADDR_W'(129 + 4 * c) && !cpu_int[c])
         |=> insvc[c] == $past(insvc[c]));

      // R8
      eoi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && !soft_rst && bus_addr == ADDR_W'(130 + 4 * c) && insvc[c] != '0)
         |=> $countones(insvc[c]) + 1 == $countones($past(insvc[c])));
   end
endmodule

bind prio_irq_ctrl pirq_chk #(.N_SRC(N_SRC), .N_CPU(N_CPU), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_rd    (bus_rd),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .cpu_int   (cpu_int),
   .soft_rst  (soft_rst),
   .insvc     (insvc)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  irq_in = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  cpu_int;
   int          checks = 0, fails = 0;

   always #4 clk = ~clk;

   prio_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_int(cpu_int)
   );

   function automatic logic [7:0] a_vp(int s);   return 8'(16 + 2 * s);  endfunction
   function automatic logic [7:0] a_dst(int s);  return 8'(17 + 2 * s);  endfunction
   function automatic logic [7:0] a_task(int c); return 8'(128 + 4 * c); endfunction
   function automatic logic [7:0] a_iack(int c); return 8'(129 + 4 * c); endfunction
   function automatic logic [7:0] a_eoi(int c);  return 8'(130 + 4 * c); endfunction
   function automatic logic [31:0] vpw(bit m, bit pol, bit lvl, int pri, int vec);
      return (32'(m) << 31) | (32'(pol) << 23) | (32'(lvl) << 22) | (32'(pri) << 16) | 32'(vec);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1 bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); bus_rd = 1'b1; bus_addr = a;
      @(posedge clk); #1 d = bus_rdata; bus_rd = 1'b0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      irq_in = '0;
      @(negedge clk); rst_n = 1'b0;
      settle(2); rst_n = 1'b1; settle(1);
   endtask

   task automatic setup(input int s, input bit lvl, input bit pol, input int pri, input int dmask);
      wr(a_dst(s), 32'(dmask));
      wr(a_vp(s), vpw(1'b0, pol, lvl, pri, 8'h40 + s));
   endtask

   task automatic t_reset();
      logic [31:0] d;
      for (int s = 0; s < 4; s++) begin
         rd(a_vp(s), d); chk("R1 vp reset", d, 32'h8008_0000 | 32'(s));
      end
      rd(a_dst(1), d);  chk("R1 dst reset", d, 32'h0);
      rd(a_task(0), d); chk("R1 task reset", d, 32'hF);
      rd(8'd2, d);      chk("R1 spurious reset", d, 32'hFF);
      rd(8'd0, d);      chk("R1 gcfg reset", d, 32'h0);
      chk("R1 int idle", 32'(cpu_int), 32'h0);
      rd(8'd1, d);      chk("R2 feature", d, 32'h0002_0103);
   endtask

   task automatic t_prio();
      logic [31:0] d;
      wr(a_task(0), 0);
      setup(0, 0, 1, 3, 1); setup(1, 0, 1, 7, 1);
      setup(2, 0, 1, 7, 1); setup(3, 0, 1, 5, 1);
      irq_in = 4'hF; settle(3);
      chk("R3 int raised", 32'(cpu_int[0]), 1);
      rd(a_iack(0), d); chk("R3 tie lowest", d, 32'h41);
      settle(1); chk("R7 nested equal blocked", 32'(cpu_int[0]), 0);
      rd(a_iack(0), d); chk("R6 spurious when blocked", d, 32'hFF);
      wr(a_eoi(0), 0);
      rd(a_iack(0), d); chk("R3 next equal", d, 32'h42);
      wr(a_eoi(0), 0);
      rd(a_iack(0), d); chk("R3 next five", d, 32'h43);
      wr(a_eoi(0), 0);
      rd(a_iack(0), d); chk("R3 lowest", d, 32'h40);
      wr(a_eoi(0), 0);
      rd(a_iack(0), d); chk("R9 one delivery per edge", d, 32'hFF);
   endtask

   task automatic t_nest();
      logic [31:0] d;
      wr(a_task(0), 0);
      setup(3, 0, 1, 5, 1); setup(1, 0, 1, 7, 1); setup(0, 0, 1, 3, 1);
      irq_in = 4'b1000; settle(3);
      rd(a_iack(0), d); chk("R3 first", d, 32'h43);
      irq_in = 4'b1010; settle(3);
      chk("R7 higher preempts", 32'(cpu_int[0]), 1);
      rd(a_iack(0), d); chk("R7 nested vector", d, 32'h41);
      irq_in = 4'b1011; settle(3);
      chk("R7 lower held", 32'(cpu_int[0]), 0);
      wr(a_eoi(0), 0); settle(1);
      chk("R8 lower still in service", 32'(cpu_int[0]), 0);
      wr(a_eoi(0), 0); settle(1);
      chk("R8 after second eoi", 32'(cpu_int[0]), 1);
      rd(a_iack(0), d); chk("R8 low delivered", d, 32'h40);
   endtask

   task automatic t_dest();
      logic [31:0] d;
      wr(a_task(0), 0); wr(a_task(1), 0);
      setup(2, 0, 1, 6, 2);
      irq_in = 4'b0100; settle(3);
      chk("R4 only cpu1", 32'(cpu_int), 32'h2);
      rd(a_iack(0), d); chk("R4 cpu0 spurious", d, 32'hFF);
      rd(a_iack(1), d); chk("R4 cpu1 vector", d, 32'h42);
   endtask

   task automatic t_task();
      logic [31:0] d;
      setup(0, 1, 1, 4, 1);
      irq_in = 4'b0001;
      wr(a_task(0), 4); settle(2);
      chk("R5 equal blocked", 32'(cpu_int[0]), 0);
      rd(a_iack(0), d); chk("R5 spurious", d, 32'hFF);
      wr(a_task(0), 3); settle(1);
      chk("R5 above passes", 32'(cpu_int[0]), 1);
      wr(a_vp(0), vpw(0, 1, 1, 15, 8'h40)); wr(a_task(0), 15); settle(1);
      chk("R5 fifteen blocks", 32'(cpu_int[0]), 0);
      wr(a_vp(0), vpw(0, 1, 1, 0, 8'h40)); wr(a_task(0), 0); settle(1);
      chk("R5 prio zero", 32'(cpu_int[0]), 0);
      wr(8'd2, 32'h5A);
      rd(a_iack(0), d); chk("R6 programmed spurious", d, 32'h5A);
   endtask

   task automatic t_level();
      logic [31:0] d;
      wr(a_task(0), 0);
      setup(0, 1, 1, 6, 1);
      irq_in = 4'b0001; settle(2);
      rd(a_iack(0), d); chk("R10 level vector", d, 32'h40);
      wr(a_eoi(0), 0); settle(1);
      chk("R10 re-presented", 32'(cpu_int[0]), 1);
      rd(a_iack(0), d);
      irq_in = 4'b0000; settle(2);
      wr(a_eoi(0), 0); settle(1);
      chk("R10 dropped", 32'(cpu_int[0]), 0);
   endtask

   task automatic t_edge();
      logic [31:0] d;
      wr(a_task(0), 0);
      irq_in = 4'b0010; settle(2);
      setup(1, 0, 0, 6, 1); settle(2);
      chk("R9 no edge yet", 32'(cpu_int[0]), 0);
      irq_in = 4'b0000; settle(3);
      rd(a_iack(0), d); chk("R9 falling edge", d, 32'h41);
      irq_in = 4'b0010; settle(2); irq_in = 4'b0000; settle(3);
      chk("R9 held in service", 32'(cpu_int[0]), 0);
      wr(a_eoi(0), 0); settle(1);
      chk("R9 latched edge after eoi", 32'(cpu_int[0]), 1);
      rd(a_iack(0), d); wr(a_eoi(0), 0); settle(1);
      chk("R9 single delivery", 32'(cpu_int[0]), 0);
   endtask

   task automatic t_mask();
      logic [31:0] d;
      wr(a_task(0), 0);
      wr(a_dst(3), 1);
      wr(a_vp(3), vpw(1, 1, 1, 9, 8'h43));
      irq_in = 4'b1000; settle(2);
      rd(a_vp(3), d); chk("R11 mask readback", d, vpw(1, 1, 1, 9, 8'h43));
      chk("R11 masked quiet", 32'(cpu_int[0]), 0);
      wr(a_vp(3), vpw(0, 1, 1, 9, 8'h43));
      rd(a_vp(3), d); chk("R11 unmask readback", d, vpw(0, 1, 1, 9, 8'h43));
      chk("R11 unmasked delivers", 32'(cpu_int[0]), 1);
   endtask

   task automatic t_soft();
      logic [31:0] d;
      wr(a_task(0), 0); setup(2, 1, 1, 6, 1);
      irq_in = 4'b0100; settle(2);
      wr(8'd0, 32'hA000_0000);
      rd(8'd0, d); chk("R12 busy bit", d, 32'h8000_0000);
      chk("R12 quiet in reset", 32'(cpu_int), 0);
      settle(10);
      rd(8'd0, d);      chk("R12 busy cleared", d, 32'h0);
      rd(a_vp(2), d);   chk("R12 vp restored", d, 32'h8008_0002);
      rd(a_task(0), d); chk("R12 task restored", d, 32'hF);
      wr(8'd0, 32'h2000_0000);
      rd(8'd0, d);      chk("R12 passthrough bit", d, 32'h2000_0000);
   endtask

   initial begin
      settle(3); rst_n = 1'b1; settle(1);
      t_reset();
      do_reset(); t_prio();
      do_reset(); t_nest();
      do_reset(); t_dest();
      do_reset(); t_task();
      do_reset(); t_level();
      do_reset(); t_edge();
      do_reset(); t_mask();
      do_reset(); t_soft();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(8 * 100000);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule